// File: doc/BRIEF.md
# Pre/Post-Trigger Acquisition Sequencer

This block runs one acquisition shot over a multi-channel sample stream. It thins the incoming stream by a programmable decimation factor, and every decimated sample taken during a shot is written, all channels at once, into a circular capture buffer. A shot first gathers a programmed number of samples ahead of the trigger. It then arms and waits for a trigger, which can be a threshold crossing on one selected channel, an edge on an external trigger line, or a software command, each gated by its own enable. After the trigger it gathers a programmed number of further samples and returns to idle.

Software drives the block through a small word-addressed register port. Through this port it issues start, stop and software-trigger commands, sets up the trigger, decimation and sample counts, and reads back the state, the buffer address of the trigger sample, a running count of decimated samples and the per-shot count. One-cycle pulses mark the trigger and the end of a shot, so an interrupt block can pick them up.

Top module: `acq_sequencer`

## Requirements
- R1: Register word offsets on `reg_addr` are: 0 command, 1 state, 2 trigger setup, 3 decimation, 4 pre count, 5 post count, 6 trigger position, 7 running sample total, 8 shot count. Reads are combinational and writes take effect on the next cycle. Offset 1 returns the state in bits [1:0]: 0 idle, 1 pre-count, 2 armed, 3 post-count. After reset the state is idle and all counters read zero.
- R2: A write to offset 0 carries a command in bits [7:0]. Value 1 is start. It is honoured only in idle: it zeroes the shot count and the write pointer and enters pre-count, or enters armed at once when the pre count is 0. A start in any other state is ignored. Value 2 is stop: it forces idle from any state on the next cycle and gives no end pulse. Value 3 is the software trigger.
- R3: Bit 31 of a write to offset 0 clears the running sample total. This works together with any command value in the same write, and the clear wins over a decimated sample arriving in the same cycle.
- R4: In the trigger setup word, bits [31:16] hold a two's-complement threshold, bit 0 selects the internal (0) or external (1) source, bit 1 selects the rising (0) or falling (1) slope, bit 2 enables the hardware trigger, bit 3 enables the software trigger, and bits [5:4] pick the channel for the internal source. An internal rising hit needs the channel's previous decimated sample below the threshold and the current one at or above it. An internal falling hit needs the previous one at or above the threshold and the current one below it. An external hit is a 0-to-1 (rising) or 1-to-0 (falling) change of `ext_trig` between two consecutive decimated samples.
- R5: One out of every N valid input samples is taken, where N is bits [15:0] of offset 3 and a value of 0 acts as 1. The count of valid inputs restarts after each write to offset 3. The running sample total rises by one per decimated sample in every state.
- R6: The shot count rises by one per decimated sample in pre-count. The block enters armed when the count equals the pre count. The count holds while armed, rises by one per sample in post-count, and the block returns to idle when it equals pre count plus post count.
- R7: Each decimated sample taken in pre-count, armed or post-count gives one `mem_we` pulse one cycle later. With that pulse, `mem_addr` is the word address of channel 0 and `mem_data` carries channel c in bits [c*16 +: 16], so channel c belongs at address + c. Nothing is written in idle or in the cycle of a start or stop command.
- R8: In armed, an enabled hardware hit or an enabled software command fires the trigger. `trig_pulse` is then high for exactly one cycle, and the trigger position becomes the address of the last pre-trigger sample. That is the sample taken in the firing cycle when a decimated sample arrives in that cycle, and otherwise the sample written last.
- R9: `eos_pulse` is high for one cycle when a shot completes and the block returns to idle. With a post count of 0 it comes in the same cycle as `trig_pulse`.
- R10: The write address steps by the channel count and wraps to 0 after the last slot of the buffer (channel count times slot count words).
- R11: Hardware and software triggers are ignored in idle and in pre-count, and a software command is ignored while bit 3 of the trigger setup is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| smp_valid | input | 1 | Input sample strobe |
| smp_data | input | NCH*SW | All channel samples, channel c in bits [c*SW +: SW] |
| ext_trig | input | 1 | External trigger level |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | clog2(NCH*BUF_SLOTS) | Buffer word address of channel 0 |
| mem_data | output | NCH*SW | Sample word for all channels |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| eos_pulse | output | 1 | One-cycle end-of-shot pulse |

## Verification
The block works from the sample, command or register write presented in a clock cycle. A register write, a state change, a buffer write and both pulses all become visible exactly one cycle after that cycle, and register reads show the stored state in the same cycle. The bench drives every stimulus on the falling edge and samples the pulses one time unit after the following rising edge. A scoreboard queue holds the expected address and data of each buffer write, and a monitor compares them at that same point. Register reads and checks that the queue has drained are done half a cycle later, so no check can race the monitor.

// File: rtl/acq_pkg.sv
package acq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_ARM  = 2'd2,
        ST_POST = 2'd3
    } acq_state_e;

    localparam logic [7:0] CMD_START = 8'd1;
    localparam logic [7:0] CMD_STOP  = 8'd2;
    localparam logic [7:0] CMD_SOFT  = 8'd3;

    localparam logic [3:0] RA_CMD  = 4'd0;
    localparam logic [3:0] RA_STAT = 4'd1;
    localparam logic [3:0] RA_TCFG = 4'd2;
    localparam logic [3:0] RA_RATE = 4'd3;
    localparam logic [3:0] RA_PRE  = 4'd4;
    localparam logic [3:0] RA_POST = 4'd5;
    localparam logic [3:0] RA_TPOS = 4'd6;
    localparam logic [3:0] RA_GCNT = 4'd7;
    localparam logic [3:0] RA_SCNT = 4'd8;

    // trigger setup word, bit 0 is the last field
    typedef struct packed {
        logic [15:0] thresh;
        logic [9:0]  spare;
        logic [1:0]  chan;
        logic        sw_en;
        logic        hw_en;
        logic        falling;
        logic        external;
    } trig_cfg_t;

endpackage

// File: rtl/acq_decimator.sv
module acq_decimator #(
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          valid,
    input  logic [RW-1:0] factor,
    output logic          tick
);
    logic [RW-1:0] cnt_d, cnt_q;
    logic [RW-1:0] last;

    always_comb begin
        last  = (factor == '0) ? '0 : factor - 1'b1;
        tick  = valid && (cnt_q >= last);
        cnt_d = cnt_q;
        if (restart)
            cnt_d = '0;
        else if (valid)
            cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/acq_trig_detect.sv
module acq_trig_detect #(
    parameter int NCH = 4,
    parameter int SW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [NCH*SW-1:0] samples,
    input  logic              ext_in,
    input  logic [15:0]       thresh,
    input  logic [1:0]        chan,
    input  logic              external,
    input  logic              falling,
    input  logic              hw_en,
    output logic              hw_hit
);
    typedef struct packed {
        logic [NCH*SW-1:0] smp;
        logic              ext;
    } hist_t;

    hist_t h_d, h_q;
    int unsigned sel;
    logic [SW-1:0] cur_raw, old_raw;
    logic signed [31:0] cur_v, old_v, thr_v;
    logic rise_int, fall_int, rise_ext, fall_ext, edge_hit;

    always_comb begin
        sel      = 32'(chan) % NCH;
        cur_raw  = samples[sel*SW +: SW];
        old_raw  = h_q.smp[sel*SW +: SW];
        cur_v    = {{(32-SW){cur_raw[SW-1]}}, cur_raw};
        old_v    = {{(32-SW){old_raw[SW-1]}}, old_raw};
        thr_v    = {{16{thresh[15]}}, thresh};
        rise_int = (old_v < thr_v) && (cur_v >= thr_v);
        fall_int = (old_v >= thr_v) && (cur_v < thr_v);
        rise_ext = !h_q.ext && ext_in;
        fall_ext = h_q.ext && !ext_in;
        if (external) edge_hit = falling ? fall_ext : rise_ext;
        else          edge_hit = falling ? fall_int : rise_int;
        hw_hit   = tick && hw_en && edge_hit;
        h_d      = h_q;
        if (tick) begin
            h_d.smp = samples;
            h_d.ext = ext_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
    import acq_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int SW        = 16,
    parameter int BUF_SLOTS = 8,
    parameter int CNT_W     = 32,
    parameter int GCNT_W    = 32,
    localparam int DEPTH    = NCH * BUF_SLOTS,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              smp_valid,
    input  logic [NCH*SW-1:0] smp_data,
    input  logic              ext_trig,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [NCH*SW-1:0] mem_data,
    output logic              trig_pulse,
    output logic              eos_pulse
);
    typedef struct packed {
        acq_state_e        st;
        trig_cfg_t         tcfg;
        logic [15:0]       rate;
        logic [CNT_W-1:0]  pre;
        logic [CNT_W-1:0]  post;
        logic [CNT_W-1:0]  shot;
        logic [GCNT_W-1:0] gcnt;
        logic [AW-1:0]     wptr;
        logic [AW-1:0]     tpos;
        logic [AW-1:0]     waddr;
        logic [NCH*SW-1:0] wdata;
        logic              we;
        logic              tp;
        logic              ep;
    } seq_t;

    seq_t sq_d, sq_q;
    logic tick, hw_hit, rate_wr;
    logic cmd_wr, soft_ok, fire;
    logic [7:0] cmd;
    logic [AW:0] ptr_sum;
    logic [AW-1:0] ptr_next, ptr_prev;
    logic [CNT_W-1:0] shot_inc, total;
    logic [1:0] st_q;

    assign rate_wr = reg_wr && (reg_addr == RA_RATE);
    assign st_q    = sq_q.st;

    acq_decimator #(.RW(16)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (rate_wr),
        .valid   (smp_valid),
        .factor  (sq_q.rate),
        .tick    (tick)
    );

    acq_trig_detect #(.NCH(NCH), .SW(SW)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .samples  (smp_data),
        .ext_in   (ext_trig),
        .thresh   (sq_q.tcfg.thresh),
        .chan     (sq_q.tcfg.chan),
        .external (sq_q.tcfg.external),
        .falling  (sq_q.tcfg.falling),
        .hw_en    (sq_q.tcfg.hw_en),
        .hw_hit   (hw_hit)
    );

    always_comb begin
        cmd      = reg_wdata[7:0];
        cmd_wr   = reg_wr && (reg_addr == RA_CMD);
        soft_ok  = cmd_wr && (cmd == CMD_SOFT) && sq_q.tcfg.sw_en;
        fire     = (sq_q.st == ST_ARM) && (hw_hit || soft_ok);
        ptr_sum  = {1'b0, sq_q.wptr} + (AW+1)'(NCH);
        ptr_next = (ptr_sum >= (AW+1)'(DEPTH)) ? '0 : ptr_sum[AW-1:0];
        ptr_prev = (sq_q.wptr < AW'(NCH)) ? AW'(DEPTH - NCH) : sq_q.wptr - AW'(NCH);
        shot_inc = sq_q.shot + 1'b1;
        total    = sq_q.pre + sq_q.post;

        sq_d    = sq_q;
        sq_d.we = 1'b0;
        sq_d.tp = 1'b0;
        sq_d.ep = 1'b0;

        if (reg_wr) begin
            case (reg_addr)
                RA_TCFG: sq_d.tcfg = trig_cfg_t'(reg_wdata);
                RA_RATE: sq_d.rate = reg_wdata[15:0];
                RA_PRE:  sq_d.pre  = reg_wdata[CNT_W-1:0];
                RA_POST: sq_d.post = reg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end

        if (tick) sq_d.gcnt = sq_q.gcnt + 1'b1;
        if (cmd_wr && reg_wdata[31]) sq_d.gcnt = '0;

        if (cmd_wr && cmd == CMD_STOP) begin
            sq_d.st = ST_IDLE;
        end else if (cmd_wr && cmd == CMD_START && sq_q.st == ST_IDLE) begin
            sq_d.st   = (sq_q.pre == '0) ? ST_ARM : ST_PRE;
            sq_d.shot = '0;
            sq_d.wptr = '0;
        end else begin
            if (tick && sq_q.st != ST_IDLE) begin
                sq_d.we    = 1'b1;
                sq_d.waddr = sq_q.wptr;
                sq_d.wdata = smp_data;
                sq_d.wptr  = ptr_next;
            end
            case (sq_q.st)
                ST_PRE: if (tick) begin
                    sq_d.shot = shot_inc;
                    if (shot_inc == sq_q.pre) sq_d.st = ST_ARM;
                end
                ST_ARM: if (fire) begin
                    sq_d.tp   = 1'b1;
                    sq_d.tpos = tick ? sq_q.wptr : ptr_prev;
                    if (sq_q.post == '0) begin
                        sq_d.st = ST_IDLE;
                        sq_d.ep = 1'b1;
                    end else begin
                        sq_d.st = ST_POST;
                    end
                end
                ST_POST: if (tick) begin
                    sq_d.shot = shot_inc;
                    if (shot_inc == total) begin
                        sq_d.st = ST_IDLE;
                        sq_d.ep = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    always_comb begin
        case (reg_addr)
            RA_STAT: reg_rdata = 32'(sq_q.st);
            RA_TCFG: reg_rdata = sq_q.tcfg;
            RA_RATE: reg_rdata = {16'b0, sq_q.rate};
            RA_PRE:  reg_rdata = 32'(sq_q.pre);
            RA_POST: reg_rdata = 32'(sq_q.post);
            RA_TPOS: reg_rdata = 32'(sq_q.tpos);
            RA_GCNT: reg_rdata = 32'(sq_q.gcnt);
            RA_SCNT: reg_rdata = 32'(sq_q.shot);
            default: reg_rdata = '0;
        endcase
    end

    assign mem_we     = sq_q.we;
    assign mem_addr   = sq_q.waddr;
    assign mem_data   = sq_q.wdata;
    assign trig_pulse = sq_q.tp;
    assign eos_pulse  = sq_q.ep;
endmodule

// File: rtl/acq_sequencer_chk.sv
module acq_sequencer_chk #(
    parameter int NCH   = 4,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [3:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic [1:0]    st_q,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          trig_pulse,
    input logic          eos_pulse
);
    // R2: stop command forces idle on the next cycle
    a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'd0 && reg_wdata[7:0] == 8'd2) |=> (st_q == 2'd0));

    // R9: end pulse only together with the idle state
    a_r9_eos_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
        eos_pulse |-> (st_q == 2'd0));

    // R8: trigger pulse lasts one cycle
    a_r8_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse);

    // R8: trigger leaves the armed state
    a_r8_trig_leaves_arm: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> (st_q == 2'd3 || st_q == 2'd0));

    // R10: writes stay inside the buffer on slot boundaries
    a_r10_addr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((32'(mem_addr) < DEPTH) && (32'(mem_addr) % NCH == 0)));

    // R7: no write decided while idle
    a_r7_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(st_q) != 2'd0));
endmodule

bind acq_sequencer acq_sequencer_chk #(.NCH(NCH), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .st_q       (st_q),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .trig_pulse (trig_pulse),
    .eos_pulse  (eos_pulse)
);

// File: tb/acq_sequencer_test.sv
module acq_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        smp_valid = 1'b0;
    logic [63:0] smp_data = '0;
    logic        ext_trig = 1'b0;
    logic        mem_we;
    logic [4:0]  mem_addr;
    logic [63:0] mem_data;
    logic        trig_pulse, eos_pulse;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct { logic [4:0] a; logic [63:0] d; } exp_t;
    exp_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    acq_sequencer uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid),
        .smp_data(smp_data), .ext_trig(ext_trig), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_data(mem_data), .trig_pulse(trig_pulse),
        .eos_pulse(eos_pulse)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input int c0, input int c1, input int c2, input int c3);
        return {16'(c3), 16'(c2), 16'(c1), 16'(c0)};
    endfunction

    // driver: one cycle of stimulus, returns just after the capturing edge
    task automatic cyc(input logic wr, input logic [3:0] a, input logic [31:0] d,
                       input logic v, input logic [63:0] s, input logic expw, input logic [4:0] ea);
        exp_t e;
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        smp_valid = v; smp_data = s;
        if (expw) begin
            e.a = ea; e.d = s;
            sbq.push_back(e);
        end
        @(posedge clk);
        #1;
        reg_wr = 1'b0; smp_valid = 1'b0;
    endtask

    task automatic wreg(input logic [3:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0, 64'd0, 1'b0, 5'd0);
    endtask

    task automatic smp(input logic [63:0] s, input logic expw, input logic [4:0] ea);
        cyc(1'b0, 4'd0, 32'd0, 1'b1, s, expw, ea);
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic drained(input string tag);
        @(negedge clk);
        chk(tag, 64'(sbq.size()), 64'd0);
    endtask

    // monitor: compares each buffer write with the scoreboard
    always @(posedge clk) begin
        #1;
        if (rst_n && mem_we) begin
            if (sbq.size() == 0) begin
                chk("R7 unexpected write addr", 64'(mem_addr), 64'h1f);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk("R7/R10 write addr", 64'(mem_addr), 64'(e.a));
                chk("R7 write data", mem_data, e.d);
            end
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // reset state (R1)
        rd(4'd1, 32'd0, "R1 reset state idle");
        rd(4'd7, 32'd0, "R1 reset total zero");
        chk("R1 reset no write", 64'(mem_we), 64'd0);
        chk("R1 reset no pulse", 64'(trig_pulse | eos_pulse), 64'd0);

        // software-triggered shot, clear combined with start (R3, R6, R8, R9)
        wreg(4'd2, 32'h0000_0008);
        wreg(4'd4, 32'd3);
        wreg(4'd5, 32'd2);
        smp(mk(1, 2, 3, 4), 1'b0, 5'd0);
        wreg(4'd0, 32'h8000_0001);
        rd(4'd1, 32'd1, "R1 pre-count state");
        rd(4'd7, 32'd0, "R3 clear with start");
        smp(mk(10, 11, 12, 13), 1'b1, 5'd0);
        smp(mk(20, 21, 22, 23), 1'b1, 5'd4);
        smp(mk(30, 31, 32, 33), 1'b1, 5'd8);
        rd(4'd1, 32'd2, "R6 armed after pre count");
        smp(mk(40, 41, 42, 43), 1'b1, 5'd12);
        smp(mk(50, 51, 52, 53), 1'b1, 5'd16);
        rd(4'd8, 32'd3, "R6 shot holds while armed");
        wreg(4'd0, 32'd3);
        chk("R8 soft trigger pulse", 64'(trig_pulse), 64'd1);
        rd(4'd1, 32'd3, "R1 post-count state");
        smp(mk(60, 61, 62, 63), 1'b1, 5'd20);
        chk("R8 trig pulse one cycle", 64'(trig_pulse), 64'd0);
        chk("R9 no early end", 64'(eos_pulse), 64'd0);
        smp(mk(70, 71, 72, 73), 1'b1, 5'd24);
        chk("R9 end pulse", 64'(eos_pulse), 64'd1);
        rd(4'd1, 32'd0, "R9 idle after shot");
        rd(4'd8, 32'd5, "R6 shot total");
        rd(4'd6, 32'd16, "R8 soft trigger position");
        rd(4'd7, 32'd7, "R5 total counts decimated samples");
        drained("R7 all shot writes seen");

        // decimation (R5), idle writes nothing (R7)
        wreg(4'd3, 32'd3);
        wreg(4'd0, 32'h8000_0000);
        for (int i = 0; i < 7; i++) smp(mk(i, i, i, i), 1'b0, 5'd0);
        rd(4'd7, 32'd2, "R5 decimate by 3");
        wreg(4'd3, 32'd0);
        wreg(4'd0, 32'h8000_0000);
        smp(mk(1, 1, 1, 1), 1'b0, 5'd0);
        smp(mk(2, 2, 2, 2), 1'b0, 5'd0);
        rd(4'd7, 32'd2, "R5 factor zero acts as one");
        drained("R7 no write in idle");

        // internal rising threshold on channel 2 (R4, R11)
        wreg(4'd2, 32'h0064_0024);
        wreg(4'd4, 32'd2);
        wreg(4'd5, 32'd1);
        wreg(4'd0, 32'd1);
        smp(mk(0, 0, 50, 0), 1'b1, 5'd0);
        smp(mk(0, 0, 200, 0), 1'b1, 5'd4);
        chk("R11 crossing in pre-count ignored", 64'(trig_pulse), 64'd0);
        smp(mk(500, 0, 150, 0), 1'b1, 5'd8);
        chk("R4 other channel crossing ignored", 64'(trig_pulse), 64'd0);
        smp(mk(0, 0, 50, 0), 1'b1, 5'd12);
        chk("R4 falling ignored in rising mode", 64'(trig_pulse), 64'd0);
        smp(mk(0, 0, 120, 0), 1'b1, 5'd16);
        chk("R4 rising crossing fires", 64'(trig_pulse), 64'd1);
        smp(mk(0, 0, 10, 0), 1'b1, 5'd20);
        chk("R9 end after post", 64'(eos_pulse), 64'd1);
        rd(4'd6, 32'd16, "R8 hardware trigger position");
        rd(4'd8, 32'd3, "R6 shot count pre plus post");

        // external falling edge, post count zero (R4, R9)
        wreg(4'd2, 32'h0000_0007);
        wreg(4'd4, 32'd1);
        wreg(4'd5, 32'd0);
        wreg(4'd0, 32'd1);
        ext_trig = 1'b1;
        smp(mk(5, 6, 7, 8), 1'b1, 5'd0);
        smp(mk(9, 9, 9, 9), 1'b1, 5'd4);
        chk("R4 steady external no trigger", 64'(trig_pulse), 64'd0);
        ext_trig = 1'b0;
        smp(mk(3, 3, 3, 3), 1'b1, 5'd8);
        chk("R4 external falling fires", 64'(trig_pulse), 64'd1);
        chk("R9 end with trigger when post zero", 64'(eos_pulse), 64'd1);
        rd(4'd6, 32'd8, "R8 external trigger position");
        rd(4'd1, 32'd0, "R9 idle after zero post");

        // disabled soft trigger, start ignored, stop (R2, R11)
        wreg(4'd2, 32'h0000_0000);
        wreg(4'd5, 32'd4);
        wreg(4'd0, 32'd1);
        smp(mk(1, 2, 3, 4), 1'b1, 5'd0);
        wreg(4'd0, 32'd3);
        chk("R11 soft trigger disabled", 64'(trig_pulse), 64'd0);
        rd(4'd1, 32'd2, "R11 still armed");
        wreg(4'd0, 32'd1);
        rd(4'd8, 32'd1, "R2 start ignored while running");
        wreg(4'd0, 32'd2);
        chk("R2 stop gives no end pulse", 64'(eos_pulse), 64'd0);
        rd(4'd1, 32'd0, "R2 stop to idle");
        smp(mk(7, 7, 7, 7), 1'b0, 5'd0);
        drained("R2 no write after stop");

        // address wrap (R10)
        wreg(4'd2, 32'h0000_0008);
        wreg(4'd4, 32'd10);
        wreg(4'd5, 32'd0);
        wreg(4'd0, 32'd1);
        for (int i = 0; i < 10; i++) smp(mk(i, i + 1, i + 2, i + 3), 1'b1, 5'((i * 4) % 32));
        rd(4'd1, 32'd2, "R10 armed after wrap");
        wreg(4'd0, 32'd3);
        chk("R9 soft trigger ends zero-post shot", 64'(eos_pulse), 64'd1);
        rd(4'd6, 32'd4, "R10 trigger position after wrap");
        drained("R10 wrapped writes seen");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule